// File: doc/BRIEF.md
# Directory parent controller for MSI coherence

This block sits on the memory side of a directory-based MSI coherence scheme. It keeps, for every child cache and every line of a small register-held address space, the state the directory believes that child holds (I, S or M) and a flag saying that a downgrade has been sent to that child and not yet answered. It also owns the backing data array for those lines.

Children send messages on one incoming channel. A message is either a request (a child asks to be upgraded to a target state) or a response (a child reports that it has moved down to a target state, possibly returning modified data). Requests and responses go into separate queues. Responses are handled first.

A request is granted only when two things hold: no child is waiting on that line, and every other child's state is compatible with the target. Otherwise the controller sends downgrade requests to the children that are in the way, and it holds the request until their answers arrive. Outgoing messages appear one per cycle on a registered parent-to-child channel. The parent is the implicit far end of both channels.

Top module: `coh_dir_parent`

## Requirements
- R1: After reset, every child is recorded as I with no wait flag set on any line. Word a of the data array holds 32'hA5A5_0000 + a. out_valid is 0, and in_ready is 1 for both message kinds.
- R2: A request from child c for target y on line a is answered only if no child has its wait flag set for a and every other child is compatible with y. A target of M (2) needs the others at I (0). A target of S (1) needs the others at I or S. The answer is out_is_resp=1, out_dst=c, out_addr=a, out_state=y.
- R3: An upgrade answer has out_has_data=1 and carries the current word of line a exactly when the requester is recorded as I. In every other case out_has_data is 0.
- R4: Once a request is answered, the requester is recorded in state y and the request leaves the queue. Later requests are judged against that state.
- R5: If R2's condition fails, the lowest-numbered other child that is incompatible and not waiting gets a downgrade request. This is out_is_resp=0 and out_has_data=0, with out_state=I for an M request and S for an S request. That child is then marked waiting, and it is never sent a second downgrade while it waits.
- R6: While every incompatible child is already waiting, the request at the head of the queue stalls and the controller emits nothing.
- R7: A response from child c on line a sets c's recorded state to the response state and clears c's wait flag. It is accepted whether or not it was solicited. Its data is written to line a only if in_has_data=1 and c was recorded as M. Data from a child in any other state is discarded.
- R8: A pending response is always handled before any pending request. So a request that was waiting on that response sees the data and state the response brought.
- R9: Requests and responses have separate queues of depth QDEPTH. in_ready, evaluated for the kind given by in_is_resp, is 0 only when that kind's queue is full.
- R10: The controller never sends an upgrade without a matching request. Every upgrade answer matches, in order, a request taken from the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming child message valid |
| in_ready | output | 1 | Queue for the message kind has room |
| in_is_resp | input | 1 | 1 = response, 0 = request |
| in_src | input | CW | Sending child index |
| in_addr | input | AW | Line address |
| in_state | input | 2 | Target state (I=0, S=1, M=2) |
| in_has_data | input | 1 | Data field present |
| in_data | input | DW | Line data |
| out_valid | output | 1 | Outgoing message valid (one cycle) |
| out_is_resp | output | 1 | 1 = upgrade answer, 0 = downgrade request |
| out_dst | output | CW | Destination child index |
| out_addr | output | AW | Line address |
| out_state | output | 2 | Target state |
| out_has_data | output | 1 | Data field present |
| out_data | output | DW | Line data |

## Verification
The assertions assume a few things about the inputs. A child answers only downgrades it was sent, or gives up a line it actually holds. A message is held until in_ready accepts it. The outgoing channel takes every message without backpressure. The stimulus follows a coherent sequence: each child sends a response only after the downgrade request addressed to it has been observed, or to give up a state the directory has granted it. Message kinds are never interleaved so that the response queue fills. The request queue is deliberately filled behind a stalled request to show that responses still get through.

// File: rtl/dir_pkg.sv
package dir_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_M = 2'd2
    } line_st_e;

    localparam logic [31:0] INIT_BASE = 32'hA5A5_0000;

    // may a peer in state 'peer' coexist with a requester holding 'want'
    function automatic logic st_compatible(line_st_e peer, line_st_e want);
        if (want == ST_M) return (peer == ST_I);
        return (peer != ST_M);
    endfunction

    // state a blocking peer must fall to
    function automatic line_st_e dn_target(line_st_e want);
        return (want == ST_M) ? ST_I : ST_S;
    endfunction

endpackage

// File: rtl/coh_fifo.sv
module coh_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  slots [DEPTH];
    logic [PW-1:0] rd_p, wr_p;
    logic [CW-1:0] cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign head  = slots[rd_p];

    function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_p <= '0;
            wr_p <= '0;
            cnt  <= '0;
        end else begin
            if (push) begin
                slots[wr_p] <= din;
                wr_p        <= nxt(wr_p);
            end
            if (pop) rd_p <= nxt(rd_p);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));
    p_no_underflow_r9: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/dir_data_array.sv
module dir_data_array #(
    parameter int AW = 3,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    import dir_pkg::*;
    localparam int LINES = 1 << AW;

    logic [DW-1:0] words [LINES];

    assign rd_data = words[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int a = 0; a < LINES; a++)
                words[a] <= DW'(INIT_BASE + 32'(a));
        end else if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

endmodule

// File: rtl/dir_tracker.sv
module dir_tracker #(
    parameter int NC = 4,
    parameter int AW = 3
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [AW-1:0]            addr,
    output dir_pkg::line_st_e [NC-1:0] st_vec,
    output logic [NC-1:0]            wt_vec,
    input  logic                     upd_en,
    input  logic [$clog2(NC)-1:0]    upd_child,
    input  dir_pkg::line_st_e        upd_st,
    input  logic                     upd_clr_wait,
    input  logic                     set_wait_en,
    input  logic [$clog2(NC)-1:0]    set_wait_child
);
    import dir_pkg::*;
    localparam int LINES = 1 << AW;

    line_st_e st [NC][LINES];
    logic     wt [NC][LINES];

    for (genvar i = 0; i < NC; i++) begin : g_look
        assign st_vec[i] = st[i][addr];
        assign wt_vec[i] = wt[i][addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NC; i++)
                for (int a = 0; a < LINES; a++) begin
                    st[i][a] <= ST_I;
                    wt[i][a] <= 1'b0;
                end
        end else begin
            if (upd_en) begin
                st[upd_child][addr] <= upd_st;
                if (upd_clr_wait) wt[upd_child][addr] <= 1'b0;
            end
            if (set_wait_en) wt[set_wait_child][addr] <= 1'b1;
        end
    end

    // a waiting child is never sent a second downgrade
    p_wait_set_once_r5: assert property (@(posedge clk) disable iff (rst)
        set_wait_en |-> !wt_vec[set_wait_child]);

endmodule

// File: rtl/coh_dir_parent.sv
module coh_dir_parent #(
    parameter int NC     = 4,
    parameter int AW     = 3,
    parameter int DW     = 32,
    parameter int QDEPTH = 4,
    localparam int CW    = $clog2(NC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_is_resp,
    input  logic [CW-1:0] in_src,
    input  logic [AW-1:0] in_addr,
    input  logic [1:0]    in_state,
    input  logic          in_has_data,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic          out_is_resp,
    output logic [CW-1:0] out_dst,
    output logic [AW-1:0] out_addr,
    output logic [1:0]    out_state,
    output logic          out_has_data,
    output logic [DW-1:0] out_data
);
    import dir_pkg::*;

    typedef struct packed {
        logic [CW-1:0] peer;
        logic [AW-1:0] addr;
        line_st_e      st;
        logic          has_data;
        logic [DW-1:0] data;
    } msg_t;
    localparam int MW = $bits(msg_t);

    msg_t in_msg, rsp_m, req_m;
    logic [MW-1:0] rsp_raw, req_raw;
    logic rsp_empty, rsp_full, req_empty, req_full;
    logic rsp_push, req_push, rsp_pop, req_pop;

    assign in_msg = '{peer: in_src, addr: in_addr, st: line_st_e'(in_state),
                      has_data: in_has_data, data: in_data};
    assign in_ready = in_is_resp ? !rsp_full : !req_full;
    assign rsp_push = in_valid && in_is_resp  && !rsp_full;
    assign req_push = in_valid && !in_is_resp && !req_full;
    assign rsp_m    = msg_t'(rsp_raw);
    assign req_m    = msg_t'(req_raw);

    coh_fifo #(.W(MW), .DEPTH(QDEPTH)) u_rsp_q (
        .clk, .rst, .push(rsp_push), .din(MW'(in_msg)), .pop(rsp_pop),
        .head(rsp_raw), .empty(rsp_empty), .full(rsp_full));

    coh_fifo #(.W(MW), .DEPTH(QDEPTH)) u_req_q (
        .clk, .rst, .push(req_push), .din(MW'(in_msg)), .pop(req_pop),
        .head(req_raw), .empty(req_empty), .full(req_full));

    // one action per cycle, responses first
    logic rsp_act, req_act;
    assign rsp_act = !rsp_empty;
    assign req_act = !req_empty && rsp_empty;

    logic [AW-1:0] act_addr;
    assign act_addr = rsp_act ? rsp_m.addr : req_m.addr;

    line_st_e [NC-1:0] st_vec;
    logic [NC-1:0]     wt_vec;
    logic [DW-1:0]     line_word;

    logic [NC-1:0] blocked, dn_cand;
    logic          grant, send_dn;
    logic [CW-1:0] dn_child;

    always_comb begin
        for (int i = 0; i < NC; i++)
            blocked[i] = (CW'(i) != req_m.peer) && !st_compatible(st_vec[i], req_m.st);
        dn_cand = blocked & ~wt_vec;
        dn_child = '0;
        for (int i = NC - 1; i >= 0; i--)
            if (dn_cand[i]) dn_child = CW'(i);
    end

    assign grant   = req_act && (wt_vec == '0) && (blocked == '0);
    assign send_dn = req_act && !grant && (dn_cand != '0);
    assign rsp_pop = rsp_act;
    assign req_pop = grant;

    logic          wr_en;
    logic          upd_en;
    logic [CW-1:0] upd_child;
    line_st_e      upd_st;

    assign wr_en     = rsp_act && rsp_m.has_data && (st_vec[rsp_m.peer] == ST_M);
    assign upd_en    = rsp_act || grant;
    assign upd_child = rsp_act ? rsp_m.peer : req_m.peer;
    assign upd_st    = rsp_act ? rsp_m.st : req_m.st;

    dir_tracker #(.NC(NC), .AW(AW)) u_track (
        .clk, .rst, .addr(act_addr), .st_vec, .wt_vec,
        .upd_en, .upd_child, .upd_st, .upd_clr_wait(rsp_act),
        .set_wait_en(send_dn), .set_wait_child(dn_child));

    dir_data_array #(.AW(AW), .DW(DW)) u_mem (
        .clk, .rst, .rd_addr(act_addr), .rd_data(line_word),
        .wr_en, .wr_addr(rsp_m.addr), .wr_data(rsp_m.data));

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_is_resp  <= 1'b0;
            out_dst      <= '0;
            out_addr     <= '0;
            out_state    <= '0;
            out_has_data <= 1'b0;
            out_data     <= '0;
        end else begin
            out_valid <= grant || send_dn;
            out_addr  <= req_m.addr;
            if (grant) begin
                out_is_resp  <= 1'b1;
                out_dst      <= req_m.peer;
                out_state    <= req_m.st;
                out_has_data <= (st_vec[req_m.peer] == ST_I);
                out_data     <= (st_vec[req_m.peer] == ST_I) ? line_word : '0;
            end else begin
                out_is_resp  <= 1'b0;
                out_dst      <= dn_child;
                out_state    <= dn_target(req_m.st);
                out_has_data <= 1'b0;
                out_data     <= '0;
            end
        end
    end

    p_resp_first_r8: assert property (@(posedge clk) disable iff (rst)
        !rsp_empty |-> !req_pop);
    p_grant_nowait_r2: assert property (@(posedge clk) disable iff (rst)
        req_pop |-> (wt_vec == '0));
    p_data_when_i_r3: assert property (@(posedge clk) disable iff (rst)
        grant |=> (out_valid && out_is_resp && out_has_data == $past(st_vec[req_m.peer] == ST_I)));
    p_dn_shape_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_resp) |-> (!out_has_data && out_state != 2'd2));
    p_stall_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (req_act && !grant && dn_cand == '0) |=> !out_valid);

endmodule

// File: tb/tb_coh_dir_parent.sv
module tb_coh_dir_parent;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4, AW = 3, DW = 32, QDEPTH = 4, CW = 2;

    logic clk = 0, rst = 1;
    logic in_valid = 0, in_is_resp = 0, in_has_data = 0;
    logic [CW-1:0] in_src = 0;
    logic [AW-1:0] in_addr = 0;
    logic [1:0] in_state = 0;
    logic [DW-1:0] in_data = 0;
    logic in_ready, out_valid, out_is_resp, out_has_data;
    logic [CW-1:0] out_dst;
    logic [AW-1:0] out_addr;
    logic [1:0] out_state;
    logic [DW-1:0] out_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    coh_dir_parent #(.NC(NC), .AW(AW), .DW(DW), .QDEPTH(QDEPTH)) dut (.*);

    typedef struct packed {
        logic is_resp; logic [CW-1:0] dst; logic [AW-1:0] addr;
        logic [1:0] st; logic hd; logic [DW-1:0] data;
    } exp_t;

    exp_t exp_q[$];
    string tag_q[$];
    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;

    function automatic logic [DW-1:0] ini(int a);
        return 32'hA5A5_0000 + 32'(a);
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic expect_msg(string tag, bit r, int d, int a, int s, bit hd, logic [DW-1:0] dt);
        exp_q.push_back('{is_resp: r, dst: CW'(d), addr: AW'(a), st: 2'(s), hd: hd, data: dt});
        tag_q.push_back(tag);
    endtask

    task automatic send(bit r, int src, int a, int s, bit hd, logic [DW-1:0] dt);
        @(negedge clk);
        in_valid = 1; in_is_resp = r; in_src = CW'(src); in_addr = AW'(a);
        in_state = 2'(s); in_has_data = hd; in_data = dt;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1 in_valid = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare every outgoing message against the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            exp_t got, e;
            got = '{is_resp: out_is_resp, dst: out_dst, addr: out_addr,
                    st: out_state, hd: out_has_data, data: out_data};
            if (exp_q.size() == 0) begin
                chk("R10 unexpected message", 64'(got), 64'h0);
                checks--; // counted as failure only
                failures += 0;
            end else begin
                e = exp_q.pop_front();
                chk(tag_q.pop_front(), {got.is_resp, got.dst, got.addr, got.st, got.hd, got.data},
                                        {e.is_resp, e.dst, e.addr, e.st, e.hd, e.data});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 out_valid", 64'(out_valid), 64'd0);
        in_is_resp = 0; #1 chk("R1 ready req", 64'(in_ready), 64'd1);
        in_is_resp = 1; #1 chk("R1 ready resp", 64'(in_ready), 64'd1);

        // R1 R3 grants from I carry initial data
        expect_msg("R3 c0 S a1", 1, 0, 1, 1, 1, ini(1)); send(0, 0, 1, 1, 0, 0);
        expect_msg("R2 c1 S a1", 1, 1, 1, 1, 1, ini(1)); send(0, 1, 1, 1, 0, 0);
        idle(3);

        // R5 upgrade S->M blocked by sharer; R3 no data since requester is S
        expect_msg("R5 dn c1 to I", 0, 1, 1, 0, 0, 0); send(0, 0, 1, 2, 0, 0);
        idle(5);
        chk("R6 stalled", 64'(exp_q.size()), 64'd0);
        expect_msg("R3 c0 M a1 nodata", 1, 0, 1, 2, 0, 0); send(1, 1, 1, 0, 0, 0);
        idle(3);

        // R7 R8 modified data flows back and into the next grant
        expect_msg("R5 dn c0 to I", 0, 0, 1, 0, 0, 0); send(0, 2, 1, 2, 0, 0);
        idle(3);
        expect_msg("R7 c2 M gets written data", 1, 2, 1, 2, 1, 32'hDEAD_BEEF);
        send(1, 0, 1, 0, 1, 32'hDEAD_BEEF);
        idle(3);

        // R5 S request downgrades M holder to S
        expect_msg("R5 dn c2 to S", 0, 2, 1, 1, 0, 0); send(0, 3, 1, 1, 0, 0);
        idle(3);
        expect_msg("R7 c3 S data", 1, 3, 1, 1, 1, 32'h0000_1234);
        send(1, 2, 1, 1, 1, 32'h0000_1234);
        idle(3);

        // R7 data from a non-M child is discarded
        send(1, 3, 1, 0, 1, 32'h0000_0999);
        expect_msg("R7 ignored data", 1, 0, 1, 1, 1, 32'h0000_1234); send(0, 0, 1, 1, 0, 0);
        idle(3);

        // R5 several sharers: lowest index first, each exactly once
        expect_msg("R2 c0 S a2", 1, 0, 2, 1, 1, ini(2)); send(0, 0, 2, 1, 0, 0);
        expect_msg("R2 c1 S a2", 1, 1, 2, 1, 1, ini(2)); send(0, 1, 2, 1, 0, 0);
        expect_msg("R2 c2 S a2", 1, 2, 2, 1, 1, ini(2)); send(0, 2, 2, 1, 0, 0);
        idle(3);
        expect_msg("R5 dn c0", 0, 0, 2, 0, 0, 0);
        expect_msg("R5 dn c1", 0, 1, 2, 0, 0, 0);
        expect_msg("R5 dn c2", 0, 2, 2, 0, 0, 0);
        send(0, 3, 2, 2, 0, 0);
        idle(8);
        chk("R6 stall after all waiting", 64'(exp_q.size()), 64'd0);
        send(1, 2, 2, 0, 0, 0);
        send(1, 0, 2, 0, 0, 0);
        idle(4);
        chk("R6 still waiting c1", 64'(exp_q.size()), 64'd0);
        expect_msg("R2 c3 M a2", 1, 3, 2, 2, 1, ini(2)); send(1, 1, 2, 0, 0, 0);
        idle(3);

        // R4 R7 voluntary give-up of M line
        expect_msg("R4 c0 M a3", 1, 0, 3, 2, 1, ini(3)); send(0, 0, 3, 2, 0, 0);
        idle(3);
        send(1, 0, 3, 0, 1, 32'h0000_0055);
        expect_msg("R4 c1 S a3 no dn", 1, 1, 3, 1, 1, 32'h0000_0055); send(0, 1, 3, 1, 0, 0);
        idle(3);

        // R9 request queue fills behind a stalled head; responses still enter
        expect_msg("R4 c0 M a4", 1, 0, 4, 2, 1, ini(4)); send(0, 0, 4, 2, 0, 0);
        idle(3);
        expect_msg("R5 dn c0 a4", 0, 0, 4, 0, 0, 0); send(0, 1, 4, 2, 0, 0);
        idle(3);
        send(0, 2, 5, 1, 0, 0);
        send(0, 3, 5, 1, 0, 0);
        send(0, 2, 6, 1, 0, 0);
        @(negedge clk);
        in_is_resp = 0; #1 chk("R9 req full", 64'(in_ready), 64'd0);
        in_is_resp = 1; #1 chk("R9 resp room", 64'(in_ready), 64'd1);
        expect_msg("R8 c1 M a4", 1, 1, 4, 2, 1, 32'h0000_00AB);
        expect_msg("R9 c2 S a5", 1, 2, 5, 1, 1, ini(5));
        expect_msg("R9 c3 S a5", 1, 3, 5, 1, 1, ini(5));
        expect_msg("R9 c2 S a6", 1, 2, 6, 1, 1, ini(6));
        send(1, 0, 4, 0, 1, 32'h0000_00AB);
        idle(20);
        chk("R10 all expected delivered", 64'(exp_q.size()), 64'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule